// File: doc/BRIEF.md
# Receive Character Queue with Status Tagging

This block buffers characters handed over by a serial receiver before a host takes them. Each character arrives as a data byte plus three line-error indications (framing, parity, break). The block stores it as a 12-bit word whose upper four bits carry those indications and an overrun mark. The host reads the oldest word from a show-ahead output and pops it with a read strobe.

The queue holds 16 words when buffering is enabled. With buffering disabled it acts as a single holding register. The storage is still present, but the full and empty flags follow a capacity of one. A character that completes while the queue is full is discarded and the stored words stay untouched. A sticky overrun flag is raised instead, and that flag is written into bit 11 of the next word that is actually stored. A level output compares the occupancy against a selectable fraction of the capacity. Interrupt or DMA logic elsewhere can use it.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, level_hit is 0, fill is 0, ovr_pending is 0 and rd_word is 0.
- R2: Words leave in arrival order. Each word is {ovr, break, parity, framing, data}, with data in bits 7:0, framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11.
- R3: With buf_en=1 the capacity is 16. full is 1 exactly when fill is 16, and empty is 1 exactly when fill is 0.
- R4: When wr_valid is high, full is 1 and no read is accepted in that cycle, the character is dropped and the stored words and fill are unchanged. ovr_pending is 1 from the next cycle.
- R5: The next character that is stored gets bit 11 equal to the pending overrun state, and ovr_pending returns to 0 in the following cycle. Words stored later carry bit 11 = 0.
- R6: A write and a read in the same cycle on a full queue are both accepted. fill stays the same and no overrun is raised.
- R7: With buf_en=0 the capacity is 1. full rises after one stored character, and a second character arriving before a read is dropped and raises overrun.
- R8: With buf_en=1, level_hit is 1 while fill is at or above the threshold chosen by lvl_sel: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, and 4 to 7 give 14. With buf_en=0, level_hit equals full.
- R9: A read strobe while empty has no effect: fill stays 0 and rd_word stays 0.
- R10: rd_word shows the oldest stored word whenever empty is 0. rd_en pops it at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_en | input | 1 | 1: 16-entry queue, 0: single holding register |
| lvl_sel | input | 3 | Threshold select for level_hit |
| wr_valid | input | 1 | Receiver has completed a character |
| wr_data | input | 8 | Received data byte |
| wr_frame | input | 1 | Framing error of this character |
| wr_parity | input | 1 | Parity error of this character |
| wr_break | input | 1 | Break condition on this character |
| rd_en | input | 1 | Host pops the oldest word |
| rd_word | output | 12 | Oldest word, zero when empty |
| full | output | 1 | No room at the current capacity |
| empty | output | 1 | Nothing stored |
| level_hit | output | 1 | Occupancy at or above threshold |
| fill | output | 5 | Number of stored words |
| ovr_pending | output | 1 | Sticky overrun awaiting the next stored word |

## Verification
The critical coincidence is a character completing in the same cycle as a host pop while the queue is full. The same cycle may also be the one in which a pending overrun gets consumed by that very write. The bench fills the queue, drops one character to arm the overrun, and then issues write and read together. The scoreboard expects the popped word to be the oldest one, the new word to carry bit 11 set and fill to hold still. A second simultaneous write and read follows, which must store a word with bit 11 clear and leave ovr_pending at 0. The single-register mode repeats the same collision at a capacity of one.

// File: rtl/rxq_pkg.sv
// Shared types for the tagged receive queue.
// Assumes: a stored word is 12 bits with the layout given in the brief.
package rxq_pkg;
    localparam int WORD_W = 12;

    typedef struct packed {
        logic       ovr;    // bit 11
        logic       brk;    // bit 10
        logic       par;    // bit 9
        logic       frm;    // bit 8
        logic [7:0] data;   // bits 7:0
    } rxq_word_t;
endpackage

// File: rtl/rxq_mem.sv
// Storage array of the queue: one write port, one asynchronous read port.
// Assumes: the array needs no reset, because the read data is masked by the
// controller while the queue is empty.
module rxq_mem #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  rxq_pkg::rxq_word_t  wdata,
    input  logic [AW-1:0]       raddr,
    output rxq_pkg::rxq_word_t  rdata
);
    rxq_pkg::rxq_word_t store [DEPTH];

    // Write a word into the slot chosen by the write pointer
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
// Pointer and occupancy control. The effective capacity is DEPTH when
// buffering is on and 1 when it is off. The storage itself is not resized.
// Assumes: DEPTH is a power of two, so the pointers wrap naturally.
module rxq_ctrl #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_mode,
    input  logic          wr_valid,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [CW-1:0] cap;

    // Capacity seen by the flags depends on the buffering mode
    assign cap   = single_mode ? CW'(1) : CW'(DEPTH);
    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign rd_ok = rd_en && !empty;
    assign wr_ok = wr_valid && (!full || rd_ok);

    // Advance pointers and occupancy on accepted transfers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) rptr <= rptr + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r4_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !rd_en) |=> (count == $past(count)) && $stable(wptr));
    a_r6_full_rdwr_count: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && rd_en) |=> (count == $past(count)));
    a_r9_empty_read_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_valid) |=> (count == '0) && $stable(rptr));
endmodule

// File: rtl/rxq_level.sv
// Threshold comparison of the occupancy against a fraction of the capacity.
// The five fractions are eighths of DEPTH, and selects above 4 reuse the
// highest one. In single-register mode the level equals "one stored".
// Assumes: DEPTH is a multiple of 8.
module rxq_level #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_mode,
    input  logic [2:0]    lvl_sel,
    input  logic [CW-1:0] count,
    output logic          level_hit
);
    localparam int NLVL = 5;

    function automatic int thr_of(input int idx);
        case (idx)
            0:       return DEPTH / 8;
            1:       return DEPTH / 4;
            2:       return DEPTH / 2;
            3:       return (3 * DEPTH) / 4;
            default: return (7 * DEPTH) / 8;
        endcase
    endfunction

    logic [NLVL-1:0] cmp;
    logic [2:0]      idx;

    // One comparator per selectable threshold
    for (genvar i = 0; i < NLVL; i++) begin : g_cmp
        localparam int THR = thr_of(i);
        assign cmp[i] = (count >= CW'(THR));
    end

    // Clamp the select and pick the comparator, or use "non-empty" in single mode
    always_comb begin
        idx       = (lvl_sel > 3'd4) ? 3'd4 : lvl_sel;
        level_hit = single_mode ? (count != '0) : cmp[idx];
    end

    a_r8_level_min: assert property (@(posedge clk) disable iff (!rst_n)
        (level_hit && !single_mode) |-> (count >= CW'(DEPTH / 8)));
endmodule

// File: rtl/rxq_tagged_fifo.sv
// Receive queue top. It stores characters with per-character error flags,
// keeps a sticky overrun flag outside the storage and merges it into the
// next stored word. It presents the oldest word show-ahead.
// Assumes: the buffering mode is changed only while the queue is empty.
module rxq_tagged_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_en,
    input  logic [2:0]    lvl_sel,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_frame,
    input  logic          wr_parity,
    input  logic          wr_break,
    input  logic          rd_en,
    output logic [11:0]   rd_word,
    output logic          full,
    output logic          empty,
    output logic          level_hit,
    output logic [CW-1:0] fill,
    output logic          ovr_pending
);
    import rxq_pkg::*;

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    rxq_word_t     wword, rword;

    rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .single_mode(!buf_en),
        .wr_valid(wr_valid), .rd_en(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
        .count(count), .full(full), .empty(empty)
    );

    // Assemble the word to store, tagging it with the pending overrun
    always_comb begin
        wword.ovr  = ovr_pending;
        wword.brk  = wr_break;
        wword.par  = wr_parity;
        wword.frm  = wr_frame;
        wword.data = wr_data;
    end

    rxq_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(wr_ok), .waddr(wptr), .wdata(wword),
        .raddr(rptr), .rdata(rword)
    );

    rxq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
        .clk(clk), .rst_n(rst_n), .single_mode(!buf_en), .lvl_sel(lvl_sel),
        .count(count), .level_hit(level_hit)
    );

    // Sticky overrun: set by a dropped character, cleared by a stored one
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_pending <= 1'b0;
        else if (wr_ok)              ovr_pending <= 1'b0;
        else if (wr_valid)           ovr_pending <= 1'b1;
    end

    assign rd_word = empty ? '0 : rword;
    assign fill    = count;

    a_r4_overrun_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && !rd_en) |=> ovr_pending);
    a_r5_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !full) |=> !ovr_pending);
    a_r6_no_overrun_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full && rd_en) |=> !ovr_pending);
    a_r7_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && fill != '0) |-> full);
endmodule

// File: tb/rxq_tagged_fifo_bench.sv
// Scoreboard bench: the driver predicts stored words into a queue, and the
// monitor pops and compares them whenever the host reads.
module rxq_tagged_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_en = 1'b1;
    logic [2:0]  lvl_sel = 3'd0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_frame = 1'b0, wr_parity = 1'b0, wr_break = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_word;
    logic        full, empty, level_hit, ovr_pending;
    logic [4:0]  fill;

    int checks = 0;
    int fails  = 0;
    logic [11:0] sb[$];
    logic        m_ovr = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rxq_tagged_fifo u_rxq_tagged_fifo (
        .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .lvl_sel(lvl_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_frame(wr_frame),
        .wr_parity(wr_parity), .wr_break(wr_break), .rd_en(rd_en),
        .rd_word(rd_word), .full(full), .empty(empty), .level_hit(level_hit),
        .fill(fill), .ovr_pending(ovr_pending)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int thr(input int s);
        case (s)
            0: return 2;  1: return 4;  2: return 8;  3: return 12;
            default: return 14;
        endcase
    endfunction

    // Monitor: mid low phase, compare the popped word with the scoreboard (R2, R10, R9)
    always @(negedge clk) begin
        #5;
        if (rst_n && rd_en) begin
            if (sb.size() > 0) chk("R2/R10 word", rd_word, sb.pop_front());
            else begin
                chk("R9 empty read word", rd_word, 0);
                chk("R9 empty flag", empty, 1);
            end
        end
    end

    // Driver: one cycle of stimulus with the predicted effect on the model
    task automatic step(input logic wv, input logic [7:0] d, input logic [2:0] fl,
                        input logic re);
        int  cap;
        logic acc;
        @(negedge clk);
        wr_valid = wv; wr_data = d;
        {wr_break, wr_parity, wr_frame} = fl;
        rd_en = re;
        cap = buf_en ? 16 : 1;
        acc = wv && ((sb.size() < cap) || (re && sb.size() > 0));
        @(posedge clk);
        if (acc) begin
            sb.push_back({m_ovr, fl, d});
            m_ovr = 1'b0;
        end else if (wv) m_ovr = 1'b1;
        #1;
        wr_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic flags(input string req);
        @(negedge clk); #2;
        chk({req, " fill"}, fill, sb.size());
        chk({req, " empty"}, empty, sb.size() == 0);
        chk({req, " full"}, full, sb.size() >= (buf_en ? 16 : 1));
        chk({req, " ovr"}, ovr_pending, m_ovr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        // R1: reset state
        chk("R1 empty", empty, 1);  chk("R1 full", full, 0);
        chk("R1 level", level_hit, 0); chk("R1 fill", fill, 0);
        chk("R1 ovr", ovr_pending, 0); chk("R1 word", rd_word, 0);
        rst_n = 1'b1;

        // R3, R8: fill to 16 with varied flags, sweep thresholds at every level
        for (int n = 1; n <= 16; n++) begin
            step(1'b1, 8'(n * 7 + 3), 3'(n % 8), 1'b0);
            @(negedge clk);
            for (int s = 0; s < 8; s++) begin
                lvl_sel = 3'(s); #1;
                chk("R8 level", level_hit, n >= thr(s));
            end
            #1;
            chk("R10 head visible", rd_word, sb[0]);
        end
        flags("R3 at 16");

        // R4: character lost at full, overrun armed
        step(1'b1, 8'hEE, 3'b111, 1'b0);
        flags("R4 drop");
        // R5, R6: write and read together on full carries the overrun mark
        step(1'b1, 8'hA5, 3'b010, 1'b1);
        flags("R5/R6 swap");
        step(1'b1, 8'h5A, 3'b001, 1'b1);
        flags("R6 swap no ovr");
        // Drain and compare through the monitor (R2, R5)
        while (sb.size() > 0) step(1'b0, 8'h00, 3'b000, 1'b1);
        flags("R3 drained");
        // R9: read on empty
        step(1'b0, 8'h00, 3'b000, 1'b1);
        flags("R9 after empty read");

        // R7: single holding register
        buf_en = 1'b0;
        step(1'b1, 8'h11, 3'b100, 1'b0);
        flags("R7 one stored");
        @(negedge clk); #1;
        chk("R8 single level", level_hit, 1);
        step(1'b1, 8'h22, 3'b000, 1'b0);
        flags("R7 overrun");
        step(1'b1, 8'h33, 3'b001, 1'b1);
        flags("R7 swap");
        step(1'b0, 8'h00, 3'b000, 1'b1);
        flags("R7 emptied");
        @(negedge clk); #1;
        chk("R8 single level empty", level_hit, 0);

        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule